// File: doc/BRIEF.md
# Multi-Channel ADC Sample Sequencer

This block drives an external successive-approximation converter core through a one-cycle request and a completion pulse. It works through a programmable list of slots, each naming one of eight physical channels. Every finished result goes into a 32-entry FIFO, tagged with the number of the channel it came from. Software sets up the slot list, the gap between samples and the run mode through a small register port. It starts and stops the engine with strobes, polls the busy flags, watches the FIFO status and drains the results through a read-to-pop register.

A single-shot run converts each slot from 0 up to the programmed last slot once and then goes idle. A continuous run wraps back to slot 0 until software stops it. A level interrupt fires while the FIFO interrupt is enabled and the fill count has reached a programmed threshold. Two processors share the converter through a pair of busy bits. The local owner writes its own bit, which is also driven out to the peer, and reads the peer's bit before it starts the engine.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x0400_0000, meaning only the empty flag at bit 26 is set. A FIFO read returns 0 and irq_o is low.
- R2: A start strobe (address 0, bit 2) is acted on only when the same write also has the enable bit (bit 0) set. A start written with bit 0 clear produces no request and leaves the busy flags clear. Writing bit 0 as 0 while running acts as a stop.
- R3: The slot list is at address 1. Slot k holds a 3-bit channel at bits 3k+2:3k, and bits 26:24 hold the last slot. A run requests the channels of slots 0..last in slot order, so a last slot of 0 gives exactly one conversion.
- R4: The FIFO is read at address 3, and each read pops one entry. An entry reads with the channel in bits 14:12 and the 12-bit result in bits 11:0, in the order the results were produced.
- R5: The three busy flags at bits 30:28 of address 0 are all set from the cycle after an accepted start until the run has ended.
- R6: Bit 1 of address 0 selects continuous mode. A single-shot run returns to idle after the last slot, while a continuous run wraps to slot 0 and keeps going.
- R7: A stop strobe (address 0, bit 14) lets a conversion already requested finish and store its result. The engine then returns to idle with the busy flags clear and issues no further requests.
- R8: With a delay count N at address 2, bits 7:0, exactly N+1 cycles pass between the cycle a result is taken and the cycle the next request is raised.
- R9: Address 0 reports the FIFO fill count modulo 32 at bits 25:21, full at bit 27 and empty at bit 26. A result arriving while the FIFO is full is dropped and sets a sticky overflow flag at bit 11, which is cleared by writing 1 to bit 11.
- R10: Reading the FIFO while it is empty returns 0 and leaves the count unchanged.
- R11: irq_o is high one cycle after the FIFO interrupt enable (address 0, bit 3) is set and the fill count is at or above the threshold held in bits 8:4. It is low otherwise.
- R12: Bit 14 of address 4 is the local owner's busy bit, readable and driven on host_busy_o. Bit 15 of address 4 reads the peer's busy input.
- R13: While a conversion is in progress, bits 18:16 of address 0 show the channel being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 3) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | FIFO level interrupt |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 3 | Channel to convert |
| conv_done_i | input | 1 | Converter result valid pulse |
| conv_data_i | input | 12 | Converter result |
| peer_busy_i | input | 1 | Peer owner's busy bit |
| host_busy_o | output | 1 | Local owner's busy bit |

## Verification
A wrong slot index or a lost stop request shows up on conv_chan_o and conv_req_o at the very next request, because the channel order or the count of requests differs from the programmed list. A miscounted gap counter shifts the next request by one or more cycles, and this is measured directly from completion to request. FIFO pointer or count errors show up as wrong tags, wrong values or wrong status bits on the first read after a run, and a full-FIFO push error is exposed when the FIFO is overfilled and the oldest 32 entries are compared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_WAIT,
    SEQ_GAP
  } seq_state_e;

  // register word addresses
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_LIST  = 3'd1;
  localparam logic [2:0] RA_DELAY = 3'd2;
  localparam logic [2:0] RA_FIFO  = 3'd3;
  localparam logic [2:0] RA_ARB   = 3'd4;

  // control / status bit positions
  localparam int B_EN      = 0;
  localparam int B_CONT    = 1;
  localparam int B_START   = 2;
  localparam int B_IRQEN   = 3;
  localparam int B_THR_LO  = 4;
  localparam int B_OVF     = 11;
  localparam int B_STOP    = 14;
  localparam int B_CUR_LO  = 16;
  localparam int B_CNT_LO  = 21;
  localparam int B_EMPTY   = 26;
  localparam int B_FULL    = 27;
  localparam int B_BUSY_LO = 28;
  localparam int B_LAST_LO = 24;
  localparam int B_HOST    = 14;
  localparam int B_PEER    = 15;
  localparam int THR_W     = 5;
  localparam int CNT_FLD_W = 5;

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               push_data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               pop_data_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       drop_o
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int CNTW = PTRW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == PTRW'(DEPTH - 1)) ? '0 : PTRW'(wptr_q + 1'b1);
    if (pop_ok)  rptr_d = (rptr_q == PTRW'(DEPTH - 1)) ? '0 : PTRW'(rptr_q + 1'b1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = CNTW'(cnt_q + 1'b1);
      2'b01:   cnt_d = CNTW'(cnt_q - 1'b1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data_i;
  end

  assign pop_data_o = empty_o ? '0 : mem[rptr_q];
  assign count_o    = cnt_q;
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CHW   = 3,
  parameter int DW    = 12,
  parameter int DLYW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_cont_i,
  input  logic [$clog2(SLOTS)-1:0] cfg_last_i,
  input  logic [SLOTS*CHW-1:0]     cfg_list_i,
  input  logic [DLYW-1:0]          cfg_dly_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  output logic                     conv_req_o,
  output logic [CHW-1:0]           conv_chan_o,
  input  logic                     conv_done_i,
  input  logic [DW-1:0]            conv_data_i,
  output logic                     push_o,
  output logic [CHW+DW-1:0]        push_word_o,
  output logic                     active_o
);
  localparam int SLW = $clog2(SLOTS);

  seq_state_e      st_q, st_d;
  logic [SLW-1:0]  slot_q, slot_d;
  logic [DLYW-1:0] gap_q, gap_d;
  logic            stop_q, stop_d;
  logic [CHW-1:0]  slot_ch [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_ch[g] = cfg_list_i[g*CHW +: CHW];
  end

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    gap_d  = gap_q;
    stop_d = stop_q;
    push_o = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          st_d   = SEQ_REQ;
          slot_d = '0;
          stop_d = 1'b0;
        end
      end
      SEQ_REQ: begin
        st_d = SEQ_WAIT;
        if (stop_i) stop_d = 1'b1;
      end
      SEQ_WAIT: begin
        if (stop_i) stop_d = 1'b1;
        if (conv_done_i) begin
          push_o = 1'b1;
          gap_d  = '0;
          if (stop_q || stop_i) begin
            st_d = SEQ_IDLE;
          end else if (slot_q == cfg_last_i) begin
            if (cfg_cont_i) begin
              slot_d = '0;
              st_d   = SEQ_GAP;
            end else begin
              st_d = SEQ_IDLE;
            end
          end else begin
            slot_d = SLW'(slot_q + 1'b1);
            st_d   = SEQ_GAP;
          end
        end
      end
      SEQ_GAP: begin
        if (stop_i)                 st_d  = SEQ_IDLE;
        else if (gap_q == cfg_dly_i) st_d = SEQ_REQ;
        else                        gap_d = DLYW'(gap_q + 1'b1);
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      slot_q <= '0;
      gap_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      gap_q  <= gap_d;
      stop_q <= stop_d;
    end
  end

  assign conv_req_o  = (st_q == SEQ_REQ);
  assign conv_chan_o = slot_ch[slot_q];
  assign push_word_o = {conv_chan_o, conv_data_i};
  assign active_o    = (st_q != SEQ_IDLE);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CHW   = 3,
  parameter int DW    = 12,
  parameter int DEPTH = 32,
  parameter int DLYW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq_o,
  output logic           conv_req_o,
  output logic [CHW-1:0] conv_chan_o,
  input  logic           conv_done_i,
  input  logic [DW-1:0]  conv_data_i,
  input  logic           peer_busy_i,
  output logic           host_busy_o
);
  localparam int SLW   = $clog2(SLOTS);
  localparam int CNTW  = $clog2(DEPTH) + 1;
  localparam int WW    = CHW + DW;
  localparam int LISTW = SLOTS * CHW;

  // configuration registers
  logic             en_q, en_d, cont_q, cont_d, irqen_q, irqen_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             ovf_q, ovf_d, host_q, host_d, irq_q, irq_d;
  logic [LISTW-1:0] list_q, list_d;
  logic [SLW-1:0]   last_q, last_d;
  logic [DLYW-1:0]  dly_q, dly_d;

  logic wr_ctrl, wr_list, wr_dly, wr_arb, start_ok, stop_req, fifo_pop;
  logic push, active, fifo_full, fifo_empty, fifo_drop;
  logic [WW-1:0]   push_word, pop_word;
  logic [CNTW-1:0] fifo_count;
  logic [31:0]     cnt_ext;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_list  = reg_wr && (reg_addr == RA_LIST);
  assign wr_dly   = reg_wr && (reg_addr == RA_DELAY);
  assign wr_arb   = reg_wr && (reg_addr == RA_ARB);
  assign start_ok = wr_ctrl && reg_wdata[B_START] && reg_wdata[B_EN];
  assign stop_req = wr_ctrl && (reg_wdata[B_STOP] || !reg_wdata[B_EN]);
  assign fifo_pop = reg_rd && (reg_addr == RA_FIFO);
  assign cnt_ext  = 32'(fifo_count);

  always_comb begin
    en_d    = en_q;
    cont_d  = cont_q;
    irqen_d = irqen_q;
    thr_d   = thr_q;
    list_d  = list_q;
    last_d  = last_q;
    dly_d   = dly_q;
    host_d  = host_q;
    ovf_d   = ovf_q;
    if (wr_ctrl) begin
      en_d    = reg_wdata[B_EN];
      cont_d  = reg_wdata[B_CONT];
      irqen_d = reg_wdata[B_IRQEN];
      thr_d   = reg_wdata[B_THR_LO +: THR_W];
      if (reg_wdata[B_OVF]) ovf_d = 1'b0;
    end
    if (fifo_drop) ovf_d = 1'b1;
    if (wr_list) begin
      list_d = reg_wdata[LISTW-1:0];
      last_d = reg_wdata[B_LAST_LO +: SLW];
    end
    if (wr_dly) dly_d  = reg_wdata[DLYW-1:0];
    if (wr_arb) host_d = reg_wdata[B_HOST];
    irq_d = irqen_q && (cnt_ext >= 32'(thr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
      irqen_q <= 1'b0;
      thr_q   <= '0;
      ovf_q   <= 1'b0;
      list_q  <= '0;
      last_q  <= '0;
      dly_q   <= '0;
      host_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      cont_q  <= cont_d;
      irqen_q <= irqen_d;
      thr_q   <= thr_d;
      ovf_q   <= ovf_d;
      list_q  <= list_d;
      last_q  <= last_d;
      dly_q   <= dly_d;
      host_q  <= host_d;
      irq_q   <= irq_d;
    end
  end

  adc_seq_engine #(.SLOTS(SLOTS), .CHW(CHW), .DW(DW), .DLYW(DLYW)) i_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cont_i  (cont_q),
    .cfg_last_i  (last_q),
    .cfg_list_i  (list_q),
    .cfg_dly_i   (dly_q),
    .start_i     (start_ok),
    .stop_i      (stop_req),
    .conv_req_o  (conv_req_o),
    .conv_chan_o (conv_chan_o),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .push_o      (push),
    .push_word_o (push_word),
    .active_o    (active)
  );

  adc_seq_fifo #(.DEPTH(DEPTH), .W(WW)) i_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (push_word),
    .pop_i       (fifo_pop),
    .pop_data_o  (pop_word),
    .count_o     (fifo_count),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty),
    .drop_o      (fifo_drop)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[B_EN]                   = en_q;
        reg_rdata[B_CONT]                 = cont_q;
        reg_rdata[B_IRQEN]                = irqen_q;
        reg_rdata[B_THR_LO +: THR_W]      = thr_q;
        reg_rdata[B_OVF]                  = ovf_q;
        reg_rdata[B_CUR_LO +: CHW]        = active ? conv_chan_o : '0;
        reg_rdata[B_CNT_LO +: CNT_FLD_W]  = cnt_ext[CNT_FLD_W-1:0];
        reg_rdata[B_EMPTY]                = fifo_empty;
        reg_rdata[B_FULL]                 = fifo_full;
        reg_rdata[B_BUSY_LO +: 3]         = {3{active}};
      end
      RA_LIST: begin
        reg_rdata[LISTW-1:0]              = list_q;
        reg_rdata[B_LAST_LO +: SLW]       = last_q;
      end
      RA_DELAY: reg_rdata[DLYW-1:0] = dly_q;
      RA_FIFO:  reg_rdata[WW-1:0]   = pop_word;
      RA_ARB: begin
        reg_rdata[B_HOST] = host_q;
        reg_rdata[B_PEER] = peer_busy_i;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o       = irq_q;
  assign host_busy_o = host_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DEPTH = 32,
  parameter int CNTW  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_ctrl,
  input logic            wbit_start,
  input logic            wbit_en,
  input logic            active,
  input logic            conv_req,
  input logic [CNTW-1:0] fifo_count,
  input logic            fifo_full,
  input logic            fifo_empty,
  input logic            fifo_pop,
  input logic            push,
  input logic            wr_arb,
  input logic            wbit_host,
  input logic            host_busy
);
  // R5: accepted start raises busy on the next cycle
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && wr_ctrl && wbit_start && wbit_en) |=> active);

  // R2: start without enable leaves the engine idle
  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && wr_ctrl && wbit_start && !wbit_en) |=> !active);

  // R3: requests only come from a running engine
  a_r3_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> active);

  // R9: count never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNTW'(DEPTH));

  // R9: full and empty never together
  a_r9_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_empty);

  // R10: popping an empty FIFO keeps it empty
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && fifo_empty && !push) |=> fifo_empty);

  // R12: local busy bit follows the written value
  a_r12_host_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arb |=> (host_busy == $past(wbit_host)));
endmodule

bind adc_seq_top adc_seq_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ctrl    (wr_ctrl),
  .wbit_start (reg_wdata[2]),
  .wbit_en    (reg_wdata[0]),
  .active     (active),
  .conv_req   (conv_req_o),
  .fifo_count (fifo_count),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .push       (push),
  .wr_arb     (wr_arb),
  .wbit_host  (reg_wdata[14]),
  .host_busy  (host_busy_o)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  logic        clk, rst_n, reg_wr, reg_rd, irq_o, conv_req_o, conv_done_i;
  logic        peer_busy_i, host_busy_o;
  logic [2:0]  reg_addr, conv_chan_o;
  logic [31:0] reg_wdata, reg_rdata;
  logic [11:0] conv_data_i;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [14:0] exp_q[$];
  logic [2:0]  req_q[$];
  int unsigned pushes = 0, seq = 0, conv_lat = 1, gap_cnt = 0, last_gap = 0;
  bit          pend = 0, counting = 0;
  int unsigned lcnt = 0;
  logic [2:0]  pend_ch;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .conv_req_o(conv_req_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .peer_busy_i(peer_busy_i), .host_busy_o(host_busy_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [11:0] sample_val(int unsigned s, logic [2:0] ch);
    return 12'((s * 173 + 32'(ch) * 29 + 7) & 32'hFFF);
  endfunction

  // converter model and monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done_i <= 1'b0;
      pend = 0;
      counting = 0;
    end else begin
      if (conv_done_i) begin
        counting = 1;
        gap_cnt = 0;
      end else if (conv_req_o && counting) begin
        last_gap = gap_cnt;
        counting = 0;
      end else if (counting) begin
        gap_cnt++;
      end
      conv_done_i <= 1'b0;
      if (conv_req_o) begin
        req_q.push_back(conv_chan_o);
        pend = 1;
        pend_ch = conv_chan_o;
        lcnt = conv_lat;
      end else if (pend) begin
        lcnt--;
        if (lcnt == 0) begin
          conv_done_i <= 1'b1;
          conv_data_i <= sample_val(seq, pend_ch);
          if (exp_q.size() < 32) exp_q.push_back({pend_ch, sample_val(seq, pend_ch)});
          seq++;
          pushes++;
          pend = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, s);
      if (s[30:28] == 3'b000) break;
    end
  endtask

  task automatic drain(input int n, input string req);
    logic [31:0] d;
    logic [14:0] e;
    for (int i = 0; i < n; i++) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 15'd0;
      rd(3'd3, d);
      chk(d == {17'd0, e}, req, d, {17'd0, e});
    end
  endtask

  function automatic logic [31:0] list_word(logic [2:0] c [8], logic [2:0] last);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[3*k +: 3] = c[k];
    w[26:24] = last;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    logic [2:0]  ch [8];
    logic [2:0]  last;
    int unsigned dly, nreq;
    bit          ok;
    void'($urandom(32'd4711));
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    peer_busy_i = 0; conv_data_i = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;

    // R1 reset state
    rd(3'd0, s); chk(s == 32'h0400_0000, "R1 reset status", s, 32'h0400_0000);
    rd(3'd3, d); chk(d == 0, "R1 reset fifo read", d, 0);
    chk(irq_o == 0, "R1 irq low", {31'd0, irq_o}, 0);

    // R2 start without enable
    for (int k = 0; k < 8; k++) ch[k] = 3'(k);
    wr(3'd1, list_word(ch, 3'd2));
    wr(3'd0, 32'h4);
    repeat (10) @(posedge clk);
    rd(3'd0, s);
    chk(s[30:28] == 0 && req_q.size() == 0, "R2 start ignored", s, 0);

    // R3 R4 R5 R8 R13 directed single shot
    ch[0] = 3'd5; ch[1] = 3'd0; ch[2] = 3'd7;
    wr(3'd1, list_word(ch, 3'd2));
    wr(3'd2, 32'd3);
    conv_lat = 2;
    wr(3'd0, 32'h5);
    rd(3'd0, s);
    chk(s[30:28] == 3'b111, "R5 busy after start", {29'd0, s[30:28]}, 32'h7);
    chk(s[18:16] == 3'd5, "R13 current channel", {29'd0, s[18:16]}, 32'd5);
    wait_idle();
    ok = (req_q.size() == 3) && req_q[0] == 5 && req_q[1] == 0 && req_q[2] == 7;
    chk(ok, "R3 slot order", req_q.size(), 3);
    chk(last_gap == 4, "R8 gap N+1", last_gap, 4);
    rd(3'd0, s);
    chk(s[25:21] == 3 && s[26] == 0, "R9 count three", {27'd0, s[25:21]}, 3);
    chk(s[30:28] == 0, "R6 single shot idle", {29'd0, s[30:28]}, 0);
    drain(3, "R4 fifo word");
    rd(3'd3, d); chk(d == 0, "R10 empty read zero", d, 0);
    rd(3'd0, s); chk(s[26] && s[25:21] == 0, "R10 count unchanged", s, 32'h0400_0000);

    // R3 last slot zero
    req_q.delete();
    wr(3'd1, list_word(ch, 3'd0));
    wr(3'd0, 32'h5);
    wait_idle();
    chk(req_q.size() == 1 && req_q[0] == 5, "R3 single slot", req_q.size(), 1);
    drain(1, "R4 single slot word");

    // random single-shot runs
    for (int it = 0; it < 8; it++) begin
      for (int k = 0; k < 8; k++) ch[k] = 3'($urandom_range(0, 7));
      last = 3'($urandom_range(0, 7));
      dly = $urandom_range(0, 6);
      conv_lat = $urandom_range(1, 4);
      req_q.delete();
      wr(3'd1, list_word(ch, last));
      wr(3'd2, dly);
      wr(3'd0, 32'h5);
      wait_idle();
      ok = (req_q.size() == int'(last) + 1);
      for (int k = 0; k < req_q.size() && k < 8; k++) ok &= (req_q[k] == ch[k]);
      chk(ok, "R3 random slot order", req_q.size(), int'(last) + 1);
      if (last != 0) chk(last_gap == dly + 1, "R8 random gap", last_gap, dly + 1);
      drain(int'(last) + 1, "R4 random fifo word");
    end

    // R6 continuous wrap and R7 stop
    ch[0] = 3'd2; ch[1] = 3'd4;
    wr(3'd1, list_word(ch, 3'd1));
    wr(3'd2, 32'd1);
    conv_lat = 4;
    req_q.delete(); pushes = 0;
    wr(3'd0, 32'h7);
    for (int i = 0; i < 2000 && req_q.size() < 5; i++) @(posedge clk);
    do @(posedge clk); while (!conv_req_o);
    wr(3'd0, 32'h4003);
    wait_idle();
    nreq = req_q.size();
    ok = nreq >= 5;
    for (int k = 0; k < nreq; k++) ok &= (req_q[k] == ((k % 2) ? 3'd4 : 3'd2));
    chk(ok, "R6 continuous wrap", nreq, 6);
    chk(pushes == nreq, "R7 in-flight finishes", pushes, nreq);
    repeat (20) @(posedge clk);
    chk(req_q.size() == nreq, "R7 no request after stop", req_q.size(), nreq);
    rd(3'd0, s); drain(int'(s[25:21]), "R7 fifo after stop");

    // R9 overflow
    ch[0] = 3'd6;
    wr(3'd1, list_word(ch, 3'd0));
    wr(3'd2, 32'd0);
    conv_lat = 1;
    pushes = 0;
    wr(3'd0, 32'h3 | 32'h4);
    for (int i = 0; i < 5000 && pushes < 34; i++) @(posedge clk);
    wr(3'd0, 32'h4001);
    wait_idle();
    rd(3'd0, s);
    chk(s[27] && !s[26] && s[25:21] == 0, "R9 full flags", s, 32'h0800_0000);
    chk(s[11] == 1, "R9 overflow sticky", {31'd0, s[11]}, 1);
    chk(irq_o == 0, "R11 irq off when disabled", {31'd0, irq_o}, 0);
    drain(32, "R9 oldest kept");
    wr(3'd0, 32'h800);
    rd(3'd0, s);
    chk(s[11] == 0 && s[26], "R9 overflow cleared", s, 32'h0400_0000);

    // R11 irq threshold
    ch[0] = 3'd1; ch[1] = 3'd2; ch[2] = 3'd3;
    wr(3'd1, list_word(ch, 3'd2));
    wr(3'd0, 32'h38 | 32'h5);
    wait_idle();
    repeat (2) @(posedge clk);
    chk(irq_o == 1, "R11 irq at threshold", {31'd0, irq_o}, 1);
    drain(1, "R11 fifo word");
    repeat (2) @(posedge clk);
    chk(irq_o == 0, "R11 irq below threshold", {31'd0, irq_o}, 0);
    drain(2, "R11 fifo word");

    // R12 arbitration
    wr(3'd4, 32'h4000);
    peer_busy_i = 1;
    rd(3'd4, d);
    chk(host_busy_o == 1 && d[15:14] == 2'b11, "R12 both busy", d, 32'hC000);
    wr(3'd4, 32'h0);
    peer_busy_i = 0;
    rd(3'd4, d);
    chk(host_busy_o == 0 && d == 0, "R12 released", d, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule